// File: doc/BRIEF.md
# Receive Elastic Buffer with Status

This block moves received data words from a recovered write clock into a local read clock. Words enter on the write side whenever the input qualifier is high. They are stored in a small dual-clock memory and leave on the read side at the read clock rate. Gray-coded pointers cross between the two domains through two-stage synchronizers. The read side computes the fill level from the synchronized write pointer.

After a re-initialization the read side waits until the fill level reaches the midpoint between the two latency thresholds. From then on it drains one word per read clock. A 3-bit status code reports whether the fill level is below the minimum latency, above the maximum latency, or in between. It also reports a sticky overflow or underflow. Once either error occurs, the stored data is treated as invalid and output stops until the buffer is re-initialized.

There are two ways to re-initialize the buffer. One is a reset input, which may be driven from any clock domain. The other, when enabled, is an automatic reset that fires after the input qualifier has stayed low for a programmable number of write cycles. A static parameter can bypass the buffer entirely.

Top module: `rx_elastic_buf`

## Requirements
- R1: While `buf_rst_n` is low, and for as long as a re-initialization lasts, `out_valid` is 0 and `buf_status` reads 3'b001.
- R2: Words accepted on the write side appear on `out_data` in the order they were written, with no loss and no repeats, while no error is present.
- R3: After re-initialization, `out_valid` stays 0 until the fill level reaches (MIN_LAT+MAX_LAT)/2. After that, one word is delivered per read clock.
- R4: When no error is present, `buf_status` reads 3'b001 if the fill level is below MIN_LAT, 3'b010 if it is above MAX_LAT, and 3'b000 otherwise.
- R5: A write attempted while the buffer is full sets overflow. `buf_status` then reads 3'b110 and holds it, and `out_valid` stays 0, until re-initialization.
- R6: A read attempted while the buffer is empty sets underflow. `buf_status` then reads 3'b101 and holds it, and `out_valid` stays 0, until re-initialization.
- R7: The overflow code overrides the underflow code, and both override the threshold codes.
- R8: Asserting and then releasing `buf_rst_n` clears a sticky error, and normal operation restarts from an empty buffer.
- R9: With IDLE_EN set, IDLE_LIMIT+1 or more consecutive write cycles with `in_valid` low re-initialize the buffer. Any cycle with `in_valid` high restarts that count, so shorter gaps have no effect.
- R10: With BYPASS set, `out_data` equals `in_data`, `out_valid` equals `in_valid`, and `buf_status` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered write clock |
| rd_clk | input | 1 | Local read clock; status is produced here |
| buf_rst_n | input | 1 | Active-low buffer re-initialization; may come from any domain |
| in_valid | input | 1 | Input word qualifier; low means no valid signal |
| in_data | input | DATA_W | Input data word |
| out_data | output | DATA_W | Output data word |
| out_valid | output | 1 | High when `out_data` carries a delivered word |
| buf_status | output | 3 | Fill and error code |

## Verification
The hardest condition to reach is a threshold code that only exists while the two clocks drift apart. Once reading starts, the fill level sits near the midpoint and moves only as fast as the rate difference allows. The bench therefore changes the write clock period between scenarios. A slightly faster write clock walks the fill level up through the high-threshold code into overflow. A slightly slower one drains it into underflow. The bench then stops writing, but for fewer cycles than the idle limit, to show that the error code stays in place. A longer silence is then used to trigger the automatic re-initialization.

// File: rtl/rxeb_pkg.sv
// Shared definitions for the receive elastic buffer.
// Assumes: status codes are fixed by the block's contract (R4..R7).
package rxeb_pkg;

    typedef enum logic [2:0] {
        ST_NOMINAL = 3'b000,
        ST_LOW     = 3'b001,
        ST_HIGH    = 3'b010,
        ST_UNDER   = 3'b101,
        ST_OVER    = 3'b110
    } rxeb_status_e;

endpackage

// File: rtl/rxeb_sync.sv
// Two-stage synchronizer for a bus that changes at most one bit at a time
// (gray pointers) or for slow level signals (resets, sticky flags).
// Assumes: stages carry no reset, so they settle within two clocks of any
// stable input.
module rxeb_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // capture then re-register to resolve metastability
    always_ff @(posedge clk) begin
        stage1 <= d;
        q      <= stage1;
    end

endmodule

// File: rtl/rxeb_wr_side.sv
// Write-domain half of the elastic buffer: write pointer (binary and gray),
// full detection against the synchronized read pointer, sticky overflow,
// and the idle counter behind the automatic re-initialization.
// Assumes: rst_n is already synchronous to clk; rgray_s comes through a
// two-stage synchronizer, so full is conservative.
module rxeb_wr_side #(
    parameter int unsigned ADDR_W     = 4,
    parameter bit          IDLE_EN    = 1'b1,
    parameter logic [3:0]  IDLE_LIMIT = 4'd15,
    localparam int unsigned PW        = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PW-1:0]     rgray_s,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PW-1:0]     wgray,
    output logic              ovf_flag,
    output logic              idle_hit
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;
    logic [PW-1:0] rbin_s;
    logic          full;
    logic          ptr_rst_n;

    // gray-to-binary of the synchronized read pointer
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            rbin_s[i] = ^(rgray_s >> i);
        end
    end

    assign full      = (wbin - rbin_s) == PW'(DEPTH);
    assign ptr_rst_n = rst_n & ~(idle_hit & ~in_valid);
    assign wr_en     = ptr_rst_n & in_valid & ~full & ~ovf_flag;
    assign wr_addr   = wbin[ADDR_W-1:0];
    assign wbin_nx   = wbin + PW'(1);

    // pointer advance and sticky overflow
    always_ff @(posedge clk) begin
        if (!ptr_rst_n) begin
            wbin     <= '0;
            wgray    <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (in_valid && full) begin
                ovf_flag <= 1'b1;
            end
            if (wr_en) begin
                wbin  <= wbin_nx;
                wgray <= (wbin_nx >> 1) ^ wbin_nx;
            end
        end
    end

    generate
        if (IDLE_EN) begin : g_idle
            logic [3:0] idle_cnt;

            // count consecutive invalid cycles; flag when the limit is passed
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    idle_cnt <= '0;
                    idle_hit <= 1'b0;
                end else if (in_valid) begin
                    idle_cnt <= '0;
                    idle_hit <= 1'b0;
                end else if (idle_cnt == IDLE_LIMIT) begin
                    idle_hit <= 1'b1;
                end else begin
                    idle_cnt <= idle_cnt + 4'd1;
                end
            end

            // R9: the idle flag is only ever seen after an invalid input cycle
            a_r9_idle_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
                idle_hit |-> !$past(in_valid));
        end else begin : g_no_idle
            assign idle_hit = 1'b0;
        end
    endgenerate

    // R2: write gray pointer moves by at most one bit per cycle
    a_r2_wgray_step: assert property (@(posedge clk) disable iff (!ptr_rst_n)
        $past(ptr_rst_n) |-> $countones(wgray ^ $past(wgray)) <= 1);

    // R5: a full buffer never advances the write pointer
    a_r5_full_holds: assert property (@(posedge clk) disable iff (!ptr_rst_n)
        full |=> $stable(wbin));

endmodule

// File: rtl/rxeb_rd_side.sv
// Read-domain half of the elastic buffer: read pointer, fill level from the
// synchronized write pointer, start-at-midpoint control, sticky underflow,
// and the registered status code with its priority order.
// Assumes: rst_n already combines the synchronized external reset and the
// synchronized idle re-initialization; ovf_s is a synchronized sticky flag.
module rxeb_rd_side
    import rxeb_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned MIN_LAT = 4,
    parameter int unsigned MAX_LAT = 10,
    localparam int unsigned PW     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     wgray_s,
    input  logic              ovf_s,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PW-1:0]     rgray,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic [2:0]        status
);

    localparam logic [PW-1:0] MIN_P = PW'(MIN_LAT);
    localparam logic [PW-1:0] MAX_P = PW'(MAX_LAT);
    localparam logic [PW-1:0] MID_P = PW'((MIN_LAT + MAX_LAT) / 2);

    logic [PW-1:0] wbin_s;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic [PW-1:0] fill;
    logic          running;
    logic          udf_flag;
    rxeb_status_e  status_q;

    // gray-to-binary of the synchronized write pointer
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            wbin_s[i] = ^(wgray_s >> i);
        end
    end

    assign fill    = wbin_s - rbin;
    assign rbin_nx = rbin + PW'(1);
    assign rd_addr = rbin[ADDR_W-1:0];
    assign status  = status_q;

    // start control, word delivery and sticky underflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin      <= '0;
            rgray     <= '0;
            running   <= 1'b0;
            udf_flag  <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (ovf_s || udf_flag) begin
            out_valid <= 1'b0;
        end else if (!running) begin
            out_valid <= 1'b0;
            if (fill >= MID_P) begin
                running <= 1'b1;
            end
        end else if (fill == '0) begin
            udf_flag  <= 1'b1;
            out_valid <= 1'b0;
        end else begin
            out_data  <= rd_word;
            out_valid <= 1'b1;
            rbin      <= rbin_nx;
            rgray     <= (rbin_nx >> 1) ^ rbin_nx;
        end
    end

    // status code with errors ahead of thresholds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= ST_LOW;
        end else if (ovf_s) begin
            status_q <= ST_OVER;
        end else if (udf_flag) begin
            status_q <= ST_UNDER;
        end else if (fill < MIN_P) begin
            status_q <= ST_LOW;
        end else if (fill > MAX_P) begin
            status_q <= ST_HIGH;
        end else begin
            status_q <= ST_NOMINAL;
        end
    end

    // R2: consecutive deliveries step the read pointer by exactly one
    a_r2_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (rbin - $past(rbin)) == PW'(1));

    // R3: first delivery only after the fill level reached the midpoint
    a_r3_start_mid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(fill, 2) >= MID_P);

    // R5: overflow code is sticky and blocks output
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == ST_OVER) |=> (status_q == ST_OVER));

    a_r5_ovf_no_out: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == ST_OVER) |-> !out_valid);

    // R6: underflow code only gives way to overflow
    a_r6_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == ST_UNDER) |=> (status_q == ST_UNDER || status_q == ST_OVER));

    // R2: read gray pointer moves by at most one bit per cycle
    a_r2_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones(rgray ^ $past(rgray)) <= 1);

endmodule

// File: rtl/rx_elastic_buf.sv
// Receive elastic buffer top: dual-clock word store between a recovered
// write clock and a local read clock, with status code, sticky errors,
// external and idle-triggered re-initialization, and a static bypass.
// Assumes: buf_rst_n is asynchronous and is synchronized into each domain
// before use; all internal resets are synchronous and active-low.
module rx_elastic_buf #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned MIN_LAT    = 4,
    parameter int unsigned MAX_LAT    = 10,
    parameter bit          BYPASS     = 1'b0,
    parameter bit          IDLE_EN    = 1'b1,
    parameter logic [3:0]  IDLE_LIMIT = 4'd15
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              buf_rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic [2:0]        buf_status
);

    localparam int unsigned PW    = ADDR_W + 1;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    generate
        if (BYPASS) begin : g_bypass
            assign out_data   = in_data;
            assign out_valid  = in_valid;
            assign buf_status = 3'b000;
        end else begin : g_buf
            logic [DATA_W-1:0] mem [DEPTH];
            logic              wr_rst_s;
            logic              rd_rst_s;
            logic              wr_en;
            logic [ADDR_W-1:0] wr_addr;
            logic [ADDR_W-1:0] rd_addr;
            logic [PW-1:0]     wgray;
            logic [PW-1:0]     rgray;
            logic [PW-1:0]     wgray_s;
            logic [PW-1:0]     rgray_s;
            logic              ovf_flag;
            logic              idle_hit;
            logic [1:0]        flags_s;
            logic              rd_rst_n;

            rxeb_sync #(.W(1)) u_wr_rst (.clk(wr_clk), .d(buf_rst_n), .q(wr_rst_s));
            rxeb_sync #(.W(1)) u_rd_rst (.clk(rd_clk), .d(buf_rst_n), .q(rd_rst_s));
            rxeb_sync #(.W(PW)) u_w2r (.clk(rd_clk), .d(wgray), .q(wgray_s));
            rxeb_sync #(.W(PW)) u_r2w (.clk(wr_clk), .d(rgray), .q(rgray_s));
            rxeb_sync #(.W(2)) u_flags (.clk(rd_clk), .d({ovf_flag, idle_hit}), .q(flags_s));

            assign rd_rst_n = rd_rst_s & ~flags_s[0];

            rxeb_wr_side #(
                .ADDR_W(ADDR_W), .IDLE_EN(IDLE_EN), .IDLE_LIMIT(IDLE_LIMIT)
            ) u_wr (
                .clk(wr_clk), .rst_n(wr_rst_s), .in_valid(in_valid),
                .rgray_s(rgray_s), .wr_en(wr_en), .wr_addr(wr_addr),
                .wgray(wgray), .ovf_flag(ovf_flag), .idle_hit(idle_hit)
            );

            // word store, written in the write domain
            always_ff @(posedge wr_clk) begin
                if (wr_en) begin
                    mem[wr_addr] <= in_data;
                end
            end

            rxeb_rd_side #(
                .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                .MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT)
            ) u_rd (
                .clk(rd_clk), .rst_n(rd_rst_n), .wgray_s(wgray_s),
                .ovf_s(flags_s[1]), .rd_word(mem[rd_addr]), .rd_addr(rd_addr),
                .rgray(rgray), .out_data(out_data), .out_valid(out_valid),
                .status(buf_status)
            );

            // R1: while re-initializing the outputs sit at their idle values
            a_r1_reinit_quiet: assert property (@(posedge rd_clk)
                (!rd_rst_n && !$past(rd_rst_n) && $past(rd_rst_n, 2))
                    |-> (!out_valid && buf_status == 3'b001));
        end
    endgenerate

endmodule

// File: tb/rx_elastic_buf_tb_top.sv
// Directed bench for rx_elastic_buf: one task per scenario, each checking
// its own results at the ports.
`timescale 1ns/1ps
module rx_elastic_buf_tb_top;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       buf_rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [7:0] out_data, b_out_data;
    logic       out_valid, b_out_valid;
    logic [2:0] buf_status, b_status;

    real        wr_half = 2.1;
    int         total = 0;
    int         bad = 0;
    int         gen_left = 0;
    logic [7:0] wseq = 8'h00;
    bit         done = 1'b0;

    always #(wr_half) wr_clk = ~wr_clk;
    always #2 rd_clk = ~rd_clk;

    rx_elastic_buf dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .buf_rst_n(buf_rst_n),
        .in_valid(in_valid), .in_data(in_data), .out_data(out_data),
        .out_valid(out_valid), .buf_status(buf_status)
    );

    rx_elastic_buf #(.BYPASS(1'b1)) byp_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .buf_rst_n(buf_rst_n),
        .in_valid(in_valid), .in_data(in_data), .out_data(b_out_data),
        .out_valid(b_out_valid), .buf_status(b_status)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rd_wait(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    // write stimulus: gen_left words (negative = endless), counting data
    task automatic wr_gen();
        forever begin
            @(negedge wr_clk);
            if (gen_left != 0) begin
                in_valid = 1'b1;
                in_data  = wseq;
                wseq     = wseq + 8'd1;
                if (gen_left > 0) gen_left--;
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic wait_burst();
        while (gen_left != 0) @(negedge wr_clk);
        @(negedge wr_clk);
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 800; i++) begin
            if (out_valid) break;
            rd_wait(1);
        end
    endtask

    task automatic do_reset(input string req);
        gen_left  = 0;
        buf_rst_n = 1'b0;
        rd_wait(10);
        chk(req, buf_status, 3'b001);
        chk(req, out_valid, 0);
        wseq      = 8'h00;
        buf_rst_n = 1'b1;
        rd_wait(4);
    endtask

    // R2 and R4: steady streaming keeps order and sits in the nominal band
    task automatic t_ordering();
        logic [7:0] exp = 8'h00;
        do_reset("R1");
        gen_left = -1;
        wait_valid();
        for (int i = 0; i < 40; i++) begin
            chk("R2 valid", out_valid, 1);
            chk("R2 data", out_data, exp);
            exp = exp + 8'd1;
            rd_wait(1);
        end
        chk("R4 nominal", buf_status, 3'b000);
        gen_left = 0;
    endtask

    // R3, R4 low band, R9 short gaps ignored
    task automatic t_threshold_low();
        do_reset("R1");
        gen_left = 3;
        wait_burst();
        rd_wait(8);
        chk("R4 low", buf_status, 3'b001);
        chk("R3 hold", out_valid, 0);
        gen_left = 3;
        wait_burst();
        rd_wait(8);
        chk("R4 mid", buf_status, 3'b000);
        chk("R3 below mid", out_valid, 0);
        gen_left = -1;
        wait_valid();
        chk("R3 start", out_valid, 1);
        chk("R9 short gap", out_data, 0);
        gen_left = 0;
    endtask

    // R4 high band, R5 sticky overflow, R7 priority
    task automatic t_overflow();
        bit seen_high = 1'b0;
        do_reset("R1");
        wr_half  = 1.8;
        gen_left = -1;
        for (int i = 0; i < 3000; i++) begin
            if (buf_status == 3'b010) seen_high = 1'b1;
            if (buf_status == 3'b110) break;
            rd_wait(1);
        end
        chk("R4 high", seen_high, 1);
        chk("R5 set", buf_status, 3'b110);
        rd_wait(30);
        chk("R5 sticky", buf_status, 3'b110);
        chk("R5 no out", out_valid, 0);
        chk("R7 over wins", buf_status, 3'b110);
        wr_half = 2.1;
    endtask

    // R9: silence on the input re-initializes, then data restarts cleanly
    t_idle_task: begin end
    task automatic t_idle();
        gen_left = 0;
        rd_wait(50);
        chk("R9 reinit status", buf_status, 3'b001);
        chk("R9 reinit valid", out_valid, 0);
        wseq     = 8'h00;
        gen_left = -1;
        wait_valid();
        chk("R9 restart", out_data, 0);
        gen_left = 0;
    endtask

    // R6 sticky underflow, R8 explicit reset recovery
    task automatic t_underflow();
        do_reset("R1");
        wr_half  = 2.3;
        gen_left = -1;
        for (int i = 0; i < 3000; i++) begin
            if (buf_status == 3'b101) break;
            rd_wait(1);
        end
        chk("R6 set", buf_status, 3'b101);
        gen_left = 0;
        rd_wait(6);
        chk("R6 sticky", buf_status, 3'b101);
        chk("R6 no out", out_valid, 0);
        wr_half = 2.1;
        do_reset("R8");
        gen_left = -1;
        wait_valid();
        chk("R8 restart", out_data, 0);
        gen_left = 0;
    endtask

    // R10: bypass passes input straight through
    task automatic t_bypass();
        gen_left = -1;
        repeat (5) begin
            @(negedge wr_clk);
            #1;
            chk("R10 data", b_out_data, in_data);
            chk("R10 valid", b_out_valid, 1);
            chk("R10 status", b_status, 3'b000);
        end
        gen_left = 0;
        repeat (2) @(negedge wr_clk);
        #1;
        chk("R10 idle", b_out_valid, 0);
    endtask

    initial begin
        fork
            wr_gen();
        join_none
        rd_wait(10);
        chk("R1 status", buf_status, 3'b001);
        chk("R1 valid", out_valid, 0);
        buf_rst_n = 1'b1;
        rd_wait(4);
        t_ordering();
        t_threshold_low();
        t_overflow();
        t_idle();
        t_underflow();
        t_bypass();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge rd_clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule